// File: doc/BRIEF.md
# Unaligned Vector Store-Left Unit

This block takes one "store vector left" operation and turns it into a single write request covering one 16-byte-aligned memory block. It forms the effective address from a base operand and an index operand. A decode flag replaces the base with literal zero when the base register number is zero. The effective address is not rounded down. Its low four bits, the offset k, decide how many leading vector bytes are stored and where they land in the aligned block.

Memory is big-endian. Vector lanes 0 through 15−k, the most significant bytes, are written to byte positions k through 15 of the aligned block. Positions below k are not enabled. Paired with a store-right issued at the effective address plus 16, the two byte-disjoint writes place a whole 16-byte vector at any alignment. One request is registered for each accepted operation. It is offered to memory on a valid/ready handshake and held steady until memory takes it.

Top module: `vsl_store_left`

## Requirements
- R1: The effective address is base plus index, modulo 2^64, and `mem_addr` equals that address with its low four bits cleared.
- R2: With k the low four bits of the effective address, `mem_be` bit i is set exactly when i ≥ k. Bit i stands for byte position i of the aligned block, counted from the lowest address.
- R3: The enabled bytes are one contiguous run that always includes byte position 15, so at least one byte is written and none outside the aligned block.
- R4: Byte position p of `mem_data` is bits [127−8p : 120−8p]. For p ≥ k it holds vector lane p−k, where lane j is `in_vec` bits [127−8j : 120−8j]. For p < k it is zero.
- R5: When k = 0, `mem_be` is 16'hFFFF and `mem_data` equals `in_vec`.
- R6: The low four bits of `mem_addr` are zero whenever `mem_valid` is high.
- R7: `in_ready` is high when no request is pending or memory is taking the pending one. Each input handshake produces exactly one request, visible the cycle after acceptance.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_be` and `mem_data` stay unchanged, and new input is refused.
- R9: After synchronous reset, `mem_valid` is low and `in_ready` is high.
- R10: When `in_base_zero` is high, the value on `in_base` has no effect, and the effective address equals `in_index`.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_vec | input | 128 | Source vector, lane 0 in the top byte |
| in_base | input | 64 | Base address operand |
| in_base_zero | input | 1 | Base register number is zero; use literal zero as the base |
| in_index | input | 64 | Index address operand |
| mem_valid | output | 1 | Write request pending |
| mem_ready | input | 1 | Memory takes the request |
| mem_addr | output | 64 | Aligned block address |
| mem_be | output | 16 | Byte enables, bit i for byte position i |
| mem_data | output | 128 | Lane-shifted write data |

## Verification
The hardest situation to reach from the ports is a back-pressured request being replaced in the same cycle that memory takes it. The bench has to stall memory, keep offering a different operation until the stall ends, and then see that the new request appears without a gap and without a duplicate. The stimulus holds `mem_ready` low for several cycles while `in_valid` stays high with new operands. It then raises `mem_ready` and checks the old request, the refused input and the replacement in turn. Address wrap past 2^64 and the zero-base flag with a non-zero base value are covered by table entries.

// File: rtl/vsl_pkg.sv
`timescale 1ns/100ps
package vsl_pkg;
    localparam int VSL_ADDR_W = 64;
    localparam int VSL_NB     = 16;
    localparam int VSL_OFF_W  = $clog2(VSL_NB);
    localparam int VSL_DATA_W = VSL_NB * 8;

    typedef logic [VSL_ADDR_W-1:0] vsl_addr_t;
    typedef logic [VSL_OFF_W-1:0]  vsl_off_t;
    typedef logic [VSL_NB-1:0]     vsl_be_t;
    typedef logic [VSL_DATA_W-1:0] vsl_data_t;

    typedef struct packed {
        vsl_addr_t blk_addr;
        vsl_be_t   be;
        vsl_data_t data;
    } vsl_req_t;

    function automatic vsl_addr_t vsl_align(input vsl_addr_t a);
        vsl_addr_t r;
        r = a;
        r[VSL_OFF_W-1:0] = '0;
        return r;
    endfunction
endpackage

// File: rtl/vsl_addr_gen.sv
`timescale 1ns/100ps
module vsl_addr_gen #(
    parameter int ADDR_W = vsl_pkg::VSL_ADDR_W,
    parameter int OFF_W  = vsl_pkg::VSL_OFF_W
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              base_zero,
    input  logic [ADDR_W-1:0] index,
    output logic [ADDR_W-1:0] blk_addr,
    output logic [OFF_W-1:0]  offset
);
    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] ea;

    always_comb begin
        base_eff = base_zero ? '0 : base;
        ea       = base_eff + index;
        offset   = ea[OFF_W-1:0];
        blk_addr = {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end
endmodule

// File: rtl/vsl_mask_gen.sv
`timescale 1ns/100ps
module vsl_mask_gen #(
    parameter int NB    = vsl_pkg::VSL_NB,
    parameter int OFF_W = vsl_pkg::VSL_OFF_W
) (
    input  logic [OFF_W-1:0] offset,
    output logic [NB-1:0]    be
);
    for (genvar i = 0; i < NB; i++) begin : g_pos
        localparam logic [OFF_W:0] POS = (OFF_W+1)'(i);
        assign be[i] = (POS >= {1'b0, offset});
    end
endmodule

// File: rtl/vsl_lane_align.sv
`timescale 1ns/100ps
module vsl_lane_align #(
    parameter int NB    = vsl_pkg::VSL_NB,
    parameter int OFF_W = vsl_pkg::VSL_OFF_W
) (
    input  logic [NB*8-1:0]  vec,
    input  logic [OFF_W-1:0] offset,
    output logic [NB*8-1:0]  data
);
    localparam int DW = NB * 8;

    logic [DW-1:0] stage [OFF_W+1];

    assign stage[0] = vec;

    for (genvar s = 0; s < OFF_W; s++) begin : g_stage
        localparam int SHIFT = 8 * (1 << s);
        assign stage[s+1] = offset[s] ? (stage[s] >> SHIFT) : stage[s];
    end

    assign data = stage[OFF_W];
endmodule

// File: rtl/vsl_req_reg.sv
`timescale 1ns/100ps
module vsl_req_reg
    import vsl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_valid,
    output logic     load_ready,
    input  vsl_req_t load_req,
    output logic     out_valid,
    input  logic     out_ready,
    output vsl_req_t out_req
);
    logic     valid_q;
    vsl_req_t req_q;
    logic     take;

    assign load_ready = !valid_q || out_ready;
    assign take       = load_valid && load_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else if (take) begin
            valid_q <= 1'b1;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (take) begin
            req_q <= load_req;
        end
    end

    assign out_valid = valid_q;
    assign out_req   = req_q;
endmodule

// File: rtl/vsl_store_left.sv
`timescale 1ns/100ps
module vsl_store_left
    import vsl_pkg::*;
#(
    parameter int ADDR_W = VSL_ADDR_W,
    parameter int NB     = VSL_NB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [NB*8-1:0]   in_vec,
    input  logic [ADDR_W-1:0] in_base,
    input  logic              in_base_zero,
    input  logic [ADDR_W-1:0] in_index,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NB-1:0]     mem_be,
    output logic [NB*8-1:0]   mem_data
);
    localparam int OFF_W = $clog2(NB);

    logic [ADDR_W-1:0] blk_addr;
    logic [OFF_W-1:0]  offset;
    logic [NB-1:0]     be;
    logic [NB*8-1:0]   shifted;
    vsl_req_t          req_in;
    vsl_req_t          req_out;

    vsl_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
        .base      (in_base),
        .base_zero (in_base_zero),
        .index     (in_index),
        .blk_addr  (blk_addr),
        .offset    (offset)
    );

    vsl_mask_gen #(.NB(NB), .OFF_W(OFF_W)) u_mask (
        .offset (offset),
        .be     (be)
    );

    vsl_lane_align #(.NB(NB), .OFF_W(OFF_W)) u_align (
        .vec    (in_vec),
        .offset (offset),
        .data   (shifted)
    );

    always_comb begin
        req_in.blk_addr = blk_addr;
        req_in.be       = be;
        req_in.data     = shifted;
    end

    vsl_req_reg u_req (
        .clk        (clk),
        .rst        (rst),
        .load_valid (in_valid),
        .load_ready (in_ready),
        .load_req   (req_in),
        .out_valid  (mem_valid),
        .out_ready  (mem_ready),
        .out_req    (req_out)
    );

    assign mem_addr = req_out.blk_addr;
    assign mem_be   = req_out.be;
    assign mem_data = req_out.data;
endmodule

// File: rtl/vsl_store_left_chk.sv
`timescale 1ns/100ps
module vsl_store_left_chk #(
    parameter int ADDR_W = 64,
    parameter int NB     = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NB-1:0]     mem_be,
    input logic [NB*8-1:0]   mem_data
);
    localparam int OFF_W = $clog2(NB);

    logic [NB*8-1:0] be_bits;
    logic [NB-1:0]   be_edge;

    for (genvar i = 0; i < NB; i++) begin : g_exp
        assign be_bits[(NB-1-i)*8 +: 8] = {8{mem_be[i]}};
    end
    assign be_edge = mem_be ^ {mem_be[NB-2:0], 1'b0};

    p_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

    p_be_shape_r3: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_be[NB-1] && ($countones(be_edge) == 1)));

    p_dead_lanes_r4: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> ((mem_data & ~be_bits) == '0));

    p_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> mem_valid);

    p_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (!mem_valid || mem_ready) |-> in_ready);

    p_drain_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !in_valid) |=> !mem_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_be) && $stable(mem_data)));

    p_refuse_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |-> !in_ready);
endmodule

bind vsl_store_left vsl_store_left_chk #(.ADDR_W(ADDR_W), .NB(NB)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_data  (mem_data)
);

// File: tb/vsl_store_left_tb.sv
`timescale 1ns/100ps
module vsl_store_left_tb;
    localparam int N = 8;
    localparam logic [127:0] VEC = 128'h00112233_44556677_8899AABB_CCDDEEFF;

    localparam logic [63:0] T_BASE [N] = '{
        64'h1000, 64'h1000, 64'h2003, 64'hDEAD,
        64'hFFFF_FFFF_FFFF_FFF8, 64'h8000_0000_0000_0001, 64'h123, 64'h7FF9};
    localparam logic [63:0] T_IDX [N] = '{
        64'h0, 64'h5, 64'hC, 64'h47, 64'h10, 64'h2, 64'h1, 64'h7};
    localparam logic T_ZERO [N] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic [63:0] T_ADDR [N] = '{
        64'h1000, 64'h1000, 64'h2000, 64'h40,
        64'h0, 64'h8000_0000_0000_0000, 64'h0, 64'h8000};
    localparam int T_K [N] = '{0, 5, 15, 7, 8, 3, 1, 0};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_vec = '0;
    logic [63:0]  in_base = '0;
    logic         in_base_zero = 1'b0;
    logic [63:0]  in_index = '0;
    logic         mem_valid;
    logic         mem_ready = 1'b1;
    logic [63:0]  mem_addr;
    logic [15:0]  mem_be;
    logic [127:0] mem_data;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    vsl_store_left u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_vec(in_vec), .in_base(in_base), .in_base_zero(in_base_zero),
        .in_index(in_index), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_data(mem_data));

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_be(input int k);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = (i >= k);
        return r;
    endfunction

    function automatic logic [127:0] exp_data(input logic [127:0] v, input int k);
        logic [127:0] r;
        r = '0;
        for (int p = 0; p < 16; p++)
            if (p >= k) r[127-8*p -: 8] = v[127-8*(p-k) -: 8];
        return r;
    endfunction

    task automatic drive(input logic [63:0] b, input logic [63:0] x, input logic z,
                         input logic [127:0] v);
        in_base = b; in_index = x; in_base_zero = z; in_vec = v; in_valid = 1'b1;
    endtask

    task automatic issue(input logic [63:0] b, input logic [63:0] x, input logic z,
                         input logic [127:0] v);
        @(negedge clk);
        drive(b, x, z, v);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0]  a0;
        logic [15:0]  b0;
        logic [127:0] d0;
        logic [127:0] v2;
        mem_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk("R9 valid", 128'(mem_valid), 128'(1'b0));
        chk("R9 ready", 128'(in_ready), 128'(1'b1));

        // table walk: R1 R2 R4 R5 R10
        for (int t = 0; t < N; t++) begin
            issue(T_BASE[t], T_IDX[t], T_ZERO[t], VEC);
            chk("R7 valid", 128'(mem_valid), 128'(1'b1));
            chk("R1 addr", 128'(mem_addr), 128'(T_ADDR[t]));
            chk("R2 be", 128'(mem_be), 128'(exp_be(T_K[t])));
            chk("R4 data", mem_data, exp_data(VEC, T_K[t]));
            if (T_K[t] == 0) begin
                chk("R5 full be", 128'(mem_be), 128'(16'hFFFF));
                chk("R5 full data", mem_data, VEC);
            end
            @(negedge clk);
            chk("R7 single", 128'(mem_valid), 128'(1'b0));
        end

        // R10: base value ignored when base_zero is set
        issue(64'hFFFF_0000_1234_5678, 64'h3A, 1'b1, VEC);
        chk("R10 addr", 128'(mem_addr), 128'(64'h30));
        chk("R10 be", 128'(mem_be), 128'(exp_be(10)));
        @(negedge clk);

        // R8/R7: stall, refuse, then replace in the handoff cycle
        v2 = 128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF;
        @(negedge clk);
        mem_ready = 1'b0;
        drive(64'h5000, 64'h9, 1'b0, VEC);
        @(negedge clk);
        a0 = mem_addr; b0 = mem_be; d0 = mem_data;
        chk("R8 first addr", 128'(a0), 128'(64'h5000));
        drive(64'h6000, 64'h2, 1'b0, v2);
        repeat (3) @(negedge clk);
        chk("R8 refuse", 128'(in_ready), 128'(1'b0));
        chk("R8 hold addr", 128'(mem_addr), 128'(a0));
        chk("R8 hold be", 128'(mem_be), 128'(b0));
        chk("R8 hold data", mem_data, d0);
        mem_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 replace valid", 128'(mem_valid), 128'(1'b1));
        chk("R7 replace addr", 128'(mem_addr), 128'(64'h6000));
        chk("R4 replace data", mem_data, exp_data(v2, 2));
        @(negedge clk);
        chk("R7 drained", 128'(mem_valid), 128'(1'b0));

        // R9: reset clears a pending request
        mem_ready = 1'b0;
        issue(64'h100, 64'h4, 1'b0, VEC);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 cleared", 128'(mem_valid), 128'(1'b0));
        mem_ready = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule